// File: doc/BRIEF.md
# Local Bus Cycle Sequencer with Back-off and Hold Arbitration

This block turns a processor-side transfer request into a cycle on a shared local bus. A request carries an address, write data and three qualifiers: memory or I/O space, write or read, and data or instruction fetch. The sequencer puts out a one-clock address strobe and then stays in a data phase until the external ready input is seen low. Each clock in which ready is not asserted adds one wait state. When a memory read sees the cache-enable input low on its first ready clock, the read becomes a line fill of four 64-bit beats. Each beat is returned to the core with its beat number.

Two inputs take the bus away from the block. The back-off input is abrupt. It releases the bus drivers in the same clock, drops the cycle in progress without completing it, and when back-off is removed the cycle starts again from its first beat. The hold input is graceful. Any cycle already running finishes all of its beats. Only then does the block float the bus and raise hold-acknowledge, and it keeps the bus until hold is removed.

The core holds its request stable until it sees the one-clock done pulse, and drops it on that clock.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After synchronous reset, bus_oe is 1 and bus_ads, hlda, cyc_done, rd_valid and breq are all 0.
- R2: A request accepted while idle raises bus_ads for exactly one clock, starting the clock after the edge that samples req_valid. During that clock bus_addr and bus_wdata equal the request, and the qualifiers read bus_mio=1 for memory, bus_wr=1 for write and bus_dc=1 for data.
- R3: In the data phase each clock with brdy_n high adds a wait state. A transfer ends on the edge where brdy_n is low, and cyc_done is high for exactly one clock after the edge that ends the last beat.
- R4: Each read beat is returned with rd_valid high for one clock after its ready edge, carrying the bus_rdata sampled at that edge and rd_beat set to the beat number.
- R5: A memory read that sees ken_n low on the ready edge of its first beat becomes a line fill of four beats, numbered 0 to 3. cyc_done follows only the fourth beat, and ken_n on later beats has no effect.
- R6: ken_n has no effect on writes and I/O reads: these always end after one beat.
- R7: While boff_n is low, bus_oe is 0 in the same clock. The cycle in progress is abandoned: no beat is taken and cyc_done does not rise, even if brdy_n is low.
- R8: After boff_n returns high, an abandoned cycle starts again with a new address strobe carrying the same address, and its beats are numbered from 0.
- R9: When hold rises during a cycle, the cycle completes all of its beats with hlda low and bus_oe high. Only then does hlda rise, with bus_oe low.
- R10: hlda falls one clock after hold is removed. bus_oe then returns high, and a request that arrived during hold starts on the next clock.
- R11: breq is high while a request is pending and not yet finished, including during hold and back-off, and low in the clock of cyc_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core has a transfer pending; held until cyc_done |
| req_is_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_is_write | input | 1 | 1 = write, 0 = read |
| req_is_data | input | 1 | 1 = data access, 0 = instruction fetch |
| req_addr | input | 29 | Quadword address of the transfer |
| req_wdata | input | 64 | Write data |
| cyc_done | output | 1 | One-clock pulse when the cycle has finished |
| rd_valid | output | 1 | A read beat is presented on rd_data |
| rd_data | output | 64 | Read beat data |
| rd_beat | output | 2 | Beat number of rd_data |
| bus_ads | output | 1 | Address strobe, first clock of a cycle |
| bus_addr | output | 29 | Bus address |
| bus_mio | output | 1 | Memory/I/O qualifier |
| bus_wr | output | 1 | Write/read qualifier |
| bus_dc | output | 1 | Data/code qualifier |
| bus_wdata | output | 64 | Bus write data |
| bus_rdata | input | 64 | Bus read data |
| bus_oe | output | 1 | 1 = drive the bus, 0 = float it |
| brdy_n | input | 1 | Active-low bus ready |
| ken_n | input | 1 | Active-low cache enable, turns a memory read into a line fill |
| boff_n | input | 1 | Active-low back-off |
| hold | input | 1 | Hold request from another master |
| hlda | output | 1 | Hold acknowledge |
| breq | output | 1 | Bus request toward the arbiter |

## Verification
The main transfer path is run over a table of cycles that mixes memory and I/O space, reads and writes, and instruction and data fetches. Each cycle uses a different number of wait states and a different cache-enable level. The qualifier pins confirm that each field is routed to its own pin. The beat counts separate a true line fill from reads and writes that merely saw cache-enable low. The wait counts show that every idle ready clock stretches the cycle by exactly one clock. Directed sequences then interrupt a line fill partway with back-off, to show that the bus floats at once and the fill restarts at beat 0. They also raise hold during a waited read, to show the acknowledge comes only after completion and that a request queued during hold starts one clock after hold-acknowledge falls.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    localparam int ADDR_W     = 29;
    localparam int DATA_W     = 64;
    localparam int FILL_BEATS = 4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_DATA = 3'd2,
        ST_DONE = 3'd3,
        ST_BOFF = 3'd4,
        ST_HOLD = 3'd5
    } bus_state_e;

    typedef struct packed {
        logic              is_mem;
        logic              is_wr;
        logic              is_data;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } cyc_req_t;

    // Only memory reads may grow into a line fill.
    function automatic logic fill_capable(cyc_req_t r);
        return r.is_mem & ~r.is_wr;
    endfunction

endpackage

// File: rtl/bcc_seq.sv
module bcc_seq
    import bcc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic brdy_n,
    input  logic boff_n,
    input  logic hold,
    input  logic last,
    output logic capture,
    output logic beat_ok,
    output logic ads,
    output logic oe,
    output logic hlda,
    output logic cyc_done,
    output logic breq
);

    bus_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!boff_n)        state_d = ST_BOFF;
                else if (hold)      state_d = ST_HOLD;
                else if (req_valid) state_d = ST_ADDR;
            end
            ST_ADDR: state_d = boff_n ? ST_DATA : ST_BOFF;
            ST_DATA: begin
                if (!boff_n)              state_d = ST_BOFF;
                else if (!brdy_n && last) state_d = ST_DONE;
            end
            ST_DONE: state_d = hold ? ST_HOLD : ST_IDLE;
            ST_BOFF: state_d = boff_n ? ST_IDLE : ST_BOFF;
            ST_HOLD: state_d = hold ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign capture  = (state_q == ST_IDLE) && (state_d == ST_ADDR);
    assign beat_ok  = (state_q == ST_DATA) && !brdy_n && boff_n;
    assign ads      = (state_q == ST_ADDR) && boff_n;
    assign oe       = boff_n && (state_q != ST_BOFF) && (state_q != ST_HOLD);
    assign hlda     = (state_q == ST_HOLD);
    assign cyc_done = (state_q == ST_DONE);
    assign breq     = req_valid && (state_q != ST_DONE);

    AST_ADS_SINGLE:    assert property (@(posedge clk) disable iff (rst) ads |=> !ads); // R2
    AST_WAIT_EXTENDS:  assert property (@(posedge clk) disable iff (rst)
                           (state_q == ST_DATA && brdy_n && boff_n) |=> state_q == ST_DATA); // R3
    AST_DONE_PULSE:    assert property (@(posedge clk) disable iff (rst) cyc_done |=> !cyc_done); // R3
    AST_BOFF_NO_DONE:  assert property (@(posedge clk) disable iff (rst) !boff_n |=> !cyc_done); // R7
    AST_HLDA_FLOATS:   assert property (@(posedge clk) disable iff (rst) hlda |-> !oe); // R9
    AST_HLDA_AFTER_CYC: assert property (@(posedge clk) disable iff (rst)
                           $rose(hlda) |-> ($past(state_q) == ST_IDLE || $past(state_q) == ST_DONE)); // R9
    AST_HLDA_RELEASE:  assert property (@(posedge clk) disable iff (rst) (hlda && !hold) |=> !hlda); // R10

endmodule

// File: rtl/bcc_beats.sv
module bcc_beats #(
    parameter  int BEATS = 4,
    localparam int BW    = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          beat_ok,
    input  logic          fill_ok,
    input  logic          ken_n,
    output logic [BW-1:0] idx,
    output logic          last
);

    logic          fill_q;
    logic [BW-1:0] cnt_q;
    logic          fill_now;

    // Cache enable counts only on the ready clock of the first beat.
    assign fill_now = fill_q | ((cnt_q == '0) & fill_ok & ~ken_n);
    assign last     = fill_now ? (cnt_q == BW'(BEATS - 1)) : 1'b1;
    assign idx      = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q  <= '0;
            fill_q <= 1'b0;
        end else if (beat_ok) begin
            fill_q <= fill_now;
            if (!last) cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_FILL_ONLY_READ: assert property (@(posedge clk) disable iff (rst) fill_q |-> fill_ok); // R6
    AST_SINGLE_NO_ADV:  assert property (@(posedge clk) disable iff (rst)
                            (beat_ok && !fill_ok) |=> cnt_q == '0); // R6

endmodule

// File: rtl/bcc_rdcap.sv
module bcc_rdcap #(
    parameter int DW = 64,
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [DW-1:0] din,
    input  logic [BW-1:0] beat_in,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [BW-1:0] rd_beat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_beat  <= '0;
        end else begin
            rd_valid <= take;
            if (take) begin
                rd_data <= din;
                rd_beat <= beat_in;
            end
        end
    end

    AST_RDV_FROM_BEAT: assert property (@(posedge clk) disable iff (rst) rd_valid |-> $past(take)); // R4

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter  int FILL_N = bcc_pkg::FILL_BEATS,
    localparam int BW     = $clog2(FILL_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_is_mem,
    input  logic              req_is_write,
    input  logic              req_is_data,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              cyc_done,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [BW-1:0]     rd_beat,
    output logic              bus_ads,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_mio,
    output logic              bus_wr,
    output logic              bus_dc,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_oe,
    input  logic              brdy_n,
    input  logic              ken_n,
    input  logic              boff_n,
    input  logic              hold,
    output logic              hlda,
    output logic              breq
);

    cyc_req_t      cur_q;
    logic          capture, beat_ok, last;
    logic [BW-1:0] beat_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else if (capture) begin
            cur_q <= '{is_mem: req_is_mem, is_wr: req_is_write, is_data: req_is_data,
                       addr: req_addr, wdata: req_wdata};
        end
    end

    bcc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .brdy_n   (brdy_n),
        .boff_n   (boff_n),
        .hold     (hold),
        .last     (last),
        .capture  (capture),
        .beat_ok  (beat_ok),
        .ads      (bus_ads),
        .oe       (bus_oe),
        .hlda     (hlda),
        .cyc_done (cyc_done),
        .breq     (breq)
    );

    bcc_beats #(.BEATS(FILL_N)) u_beats (
        .clk    (clk),
        .rst    (rst),
        .clear  (capture),
        .beat_ok(beat_ok),
        .fill_ok(fill_capable(cur_q)),
        .ken_n  (ken_n),
        .idx    (beat_idx),
        .last   (last)
    );

    bcc_rdcap #(.DW(DATA_W), .BW(BW)) u_rdcap (
        .clk     (clk),
        .rst     (rst),
        .take    (beat_ok && !cur_q.is_wr),
        .din     (bus_rdata),
        .beat_in (beat_idx),
        .rd_valid(rd_valid),
        .rd_data (rd_data),
        .rd_beat (rd_beat)
    );

    assign bus_addr  = cur_q.addr;
    assign bus_mio   = cur_q.is_mem;
    assign bus_wr    = cur_q.is_wr;
    assign bus_dc    = cur_q.is_data;
    assign bus_wdata = cur_q.wdata;

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
                         (bus_ads && boff_n) |=> $stable(bus_addr)); // R2
    AST_WR_NO_RDV:   assert property (@(posedge clk) disable iff (rst) (rd_valid && !cyc_done) |-> !bus_wr); // R4

endmodule

// File: tb/tb_bus_cycle_ctrl.sv
`timescale 1ns/1ps
module tb_bus_cycle_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_is_mem, req_is_write, req_is_data;
    logic [28:0] req_addr;
    logic [63:0] req_wdata;
    logic        cyc_done, rd_valid;
    logic [63:0] rd_data;
    logic [1:0]  rd_beat;
    logic        bus_ads;
    logic [28:0] bus_addr;
    logic        bus_mio, bus_wr, bus_dc;
    logic [63:0] bus_wdata, bus_rdata;
    logic        bus_oe, brdy_n, ken_n, boff_n, hold, hlda, breq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bus_cycle_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_mem(req_is_mem),
        .req_is_write(req_is_write), .req_is_data(req_is_data), .req_addr(req_addr),
        .req_wdata(req_wdata), .cyc_done(cyc_done), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_beat(rd_beat), .bus_ads(bus_ads), .bus_addr(bus_addr), .bus_mio(bus_mio),
        .bus_wr(bus_wr), .bus_dc(bus_dc), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_oe(bus_oe), .brdy_n(brdy_n), .ken_n(ken_n), .boff_n(boff_n), .hold(hold),
        .hlda(hlda), .breq(breq)
    );

    typedef struct packed {
        logic        mem;
        logic        wr;
        logic        dc;
        logic        ken;
        logic [3:0]  waits;
        logic [3:0]  beats;
        logic [28:0] addr;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 4'd1, 29'h0000_1000},  // plain memory data read
        '{1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 4'd4, 29'h0000_2040},  // code fetch line fill
        '{1'b1, 1'b1, 1'b1, 1'b0, 4'd1, 4'd1, 29'h0ABC_0008},  // write ignores ken_n
        '{1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd1, 29'h0000_0060},  // I/O read ignores ken_n
        '{1'b0, 1'b1, 1'b1, 1'b1, 4'd3, 4'd1, 29'h0000_0071},  // I/O write, long wait
        '{1'b1, 1'b0, 1'b1, 1'b0, 4'd1, 4'd4, 29'h1FFF_FFF8}   // data line fill
    };

    function automatic logic [63:0] pat(input logic [28:0] a, input int b);
        return {3'b000, a, 24'h5A5A5A, 8'(b)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Presents a request and checks the address clock.
    task automatic issue(input logic mem, input logic wr, input logic dc, input logic [28:0] a);
        @(negedge clk);
        req_is_mem = mem; req_is_write = wr; req_is_data = dc;
        req_addr = a; req_wdata = {3'b000, a, ~a[28:0], 3'b101};
        req_valid = 1'b1;
        @(negedge clk);
        chk(bus_ads == 1'b1, "R2 ads", 64'(bus_ads), 64'd1);
        chk(bus_addr == a, "R2 addr", 64'(bus_addr), 64'(a));
        chk({bus_mio, bus_wr, bus_dc} == {mem, wr, dc}, "R2 qualifiers",
            64'({bus_mio, bus_wr, bus_dc}), 64'({mem, wr, dc}));
        if (wr) chk(bus_wdata == req_wdata, "R2 wdata", bus_wdata, req_wdata);
        chk(breq == 1'b1, "R11 breq pending", 64'(breq), 64'd1);
    endtask

    // From the address clock, runs the data phase and the done clock.
    task automatic beats(input logic [28:0] a, input logic wr, input logic ken,
                         input int waits, input int n);
        brdy_n = 1'b1;
        @(negedge clk);
        for (int b = 0; b < n; b++) begin
            for (int w = 0; w < waits; w++) begin
                brdy_n = 1'b1;
                @(negedge clk);
                chk(cyc_done == 1'b0 && rd_valid == 1'b0, "R3 wait state",
                    64'({cyc_done, rd_valid}), 64'd0);
            end
            brdy_n = 1'b0;
            ken_n = (b == 0) ? ken : 1'b1;
            bus_rdata = pat(a, b);
            @(negedge clk);
            if (!wr) begin
                chk(rd_valid == 1'b1, "R4 rd_valid", 64'(rd_valid), 64'd1);
                chk(rd_data == pat(a, b), "R4 rd_data", rd_data, pat(a, b));
                chk(rd_beat == 2'(b), "R5 beat number", 64'(rd_beat), 64'(b));
            end else begin
                chk(rd_valid == 1'b0, "R4 no rd_valid on write", 64'(rd_valid), 64'd0);
            end
            if (b < n - 1)
                chk(cyc_done == 1'b0, "R5 no early done", 64'(cyc_done), 64'd0);
        end
        chk(cyc_done == 1'b1, "R3 R5 R6 done after last beat", 64'(cyc_done), 64'd1);
        chk(breq == 1'b0, "R11 breq low at done", 64'(breq), 64'd0);
        req_valid = 1'b0; brdy_n = 1'b1; ken_n = 1'b1;
        @(negedge clk);
        chk(cyc_done == 1'b0, "R3 done one clock", 64'(cyc_done), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_is_mem = 1'b0; req_is_write = 1'b0;
        req_is_data = 1'b0; req_addr = '0; req_wdata = '0; bus_rdata = '0;
        brdy_n = 1'b1; ken_n = 1'b1; boff_n = 1'b1; hold = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(bus_oe == 1'b1, "R1 oe", 64'(bus_oe), 64'd1);
        chk({bus_ads, hlda, cyc_done, rd_valid, breq} == 5'b0, "R1 idle outputs",
            64'({bus_ads, hlda, cyc_done, rd_valid, breq}), 64'd0);

        // Table walk: R2 R3 R4 R5 R6
        foreach (VECS[i]) begin
            issue(VECS[i].mem, VECS[i].wr, VECS[i].dc, VECS[i].addr);
            beats(VECS[i].addr, VECS[i].wr, VECS[i].ken, int'(VECS[i].waits), int'(VECS[i].beats));
        end

        // Back-off in the middle of a line fill: R7 R8
        issue(1'b1, 1'b0, 1'b1, 29'h0000_3300);
        brdy_n = 1'b1;
        @(negedge clk);
        brdy_n = 1'b0; ken_n = 1'b0; bus_rdata = pat(29'h0000_3300, 0);
        @(negedge clk);
        chk(rd_beat == 2'd0 && rd_valid, "R5 fill beat 0", 64'(rd_beat), 64'd0);
        ken_n = 1'b1; bus_rdata = pat(29'h0000_3300, 1);
        @(negedge clk);
        chk(rd_beat == 2'd1 && rd_valid, "R5 fill beat 1", 64'(rd_beat), 64'd1);
        brdy_n = 1'b1;
        @(negedge clk);
        boff_n = 1'b0; brdy_n = 1'b0;
        #1;
        chk(bus_oe == 1'b0, "R7 float same clock", 64'(bus_oe), 64'd0);
        @(negedge clk);
        chk(rd_valid == 1'b0 && cyc_done == 1'b0, "R7 no beat while backed off",
            64'({rd_valid, cyc_done}), 64'd0);
        chk(bus_oe == 1'b0 && breq == 1'b1, "R7 R11 floated, still requesting",
            64'({bus_oe, breq}), 64'b01);
        @(negedge clk);
        chk(cyc_done == 1'b0, "R7 no done", 64'(cyc_done), 64'd0);
        boff_n = 1'b1; brdy_n = 1'b1;
        @(negedge clk);
        chk(bus_oe == 1'b1 && bus_ads == 1'b0, "R8 drive again",
            64'({bus_oe, bus_ads}), 64'b10);
        @(negedge clk);
        chk(bus_ads == 1'b1 && bus_addr == 29'h0000_3300, "R8 restart strobe",
            64'(bus_addr), 64'h3300);
        beats(29'h0000_3300, 1'b0, 1'b0, 0, 4);  // R8 beats again from 0

        // Hold during a waited read: R9 R10 R11
        issue(1'b1, 1'b0, 1'b1, 29'h0000_4400);
        brdy_n = 1'b1;
        @(negedge clk);
        hold = 1'b1;
        @(negedge clk);
        chk(hlda == 1'b0 && bus_oe == 1'b1, "R9 cycle continues under hold",
            64'({hlda, bus_oe}), 64'b01);
        brdy_n = 1'b0; bus_rdata = pat(29'h0000_4400, 0);
        @(negedge clk);
        chk(cyc_done == 1'b1 && hlda == 1'b0, "R9 completes before ack",
            64'({cyc_done, hlda}), 64'b10);
        req_valid = 1'b0; brdy_n = 1'b1;
        @(negedge clk);
        chk(hlda == 1'b1 && bus_oe == 1'b0, "R9 ack and float", 64'({hlda, bus_oe}), 64'b10);
        req_is_mem = 1'b0; req_is_write = 1'b1; req_is_data = 1'b1;
        req_addr = 29'h0000_0055; req_wdata = 64'h1234;
        req_valid = 1'b1;
        @(negedge clk);
        chk(bus_ads == 1'b0 && hlda == 1'b1, "R9 no start while held",
            64'({bus_ads, hlda}), 64'b01);
        chk(breq == 1'b1, "R11 breq during hold", 64'(breq), 64'd1);
        hold = 1'b0;
        @(negedge clk);
        chk(hlda == 1'b0 && bus_oe == 1'b1, "R10 ack drops", 64'({hlda, bus_oe}), 64'b01);
        @(negedge clk);
        chk(bus_ads == 1'b1 && bus_addr == 29'h0000_0055 && bus_wr == 1'b1,
            "R10 queued request starts", 64'(bus_addr), 64'h55);
        beats(29'h0000_0055, 1'b1, 1'b1, 0, 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule